// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Byte Lanes

This block connects a clocked host to a 64K x 16 asynchronous static RAM. The host asks for one word access at a time: a read or a write, a word address, write data and a two-bit lane mask. The controller turns each request into a sequence of active-low strobes on the memory pins. When the access is finished it returns a one-cycle completion pulse, and for reads it also returns the captured data.

Each strobe width is a whole number of clock cycles. The counts come from the memory's timing limits, given in picoseconds as parameters and rounded up against the clock period. Write data leaves on a separate output bus with its own drive-enable, which steers an external tristate buffer. Read data comes back on an input bus. The controller keeps output enable high for the whole of every write. This lets the write strobe use the short minimum width instead of the longer one that applies when the memory's outputs must first be turned off. Drive is held back after a read until the memory has had time to release the bus.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted, every memory strobe is high (chip select, write strobe, output enable, both lane enables), the drive-enable is low, done is low and read data is zero.
- R2: In a write, chip select and the lane enables fall one cycle before the write strobe. With the default timing the write strobe stays low for exactly one cycle, and output enable is high in every cycle of the write.
- R3: Mask bit 0 selects data bits 7:0 and drives lane-enable bit 0 low. Mask bit 1 selects bits 15:8 through lane-enable bit 1. A write leaves the unselected lane of the stored word unchanged.
- R4: In a read, chip select, output enable and the selected lane enables stay low together for exactly two cycles with the default timing. The memory data is captured on the clock edge that ends that window.
- R5: A lane that was not selected in a read returns zero in the read data.
- R6: Done is high for one cycle per completed access. For a read or a write, that cycle starts on the third rising edge, counting the edge that accepts the request. Done never appears without a request.
- R7: A request with mask 00 raises done on the edge right after acceptance. It pulls no strobe low, stores nothing, and leaves the read data unchanged.
- R8: A request presented in the done cycle is accepted there, and the next access starts on the following edge with no idle cycle between.
- R9: A request presented while an access is in its setup or strobe phase is dropped and has no effect on the memory.
- R10: The drive-enable is never high while output enable is low, nor in the cycle right after output enable was low. It is low in the done cycle of a write.
- R11: While chip select stays low from one cycle to the next, the address and lane enables do not change.
- R12: The drive-enable is high in every cycle in which the write strobe is low, and the write data bus holds the request's data throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, taken when idle or in the done cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = low byte, bit 1 = high byte |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read data, unselected lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| mem_wdata | output | 16 | Data toward the external tristate buffer |
| mem_wdata_oe | output | 1 | Drive-enable for the external buffer |
| mem_rdata | input | 16 | Data from the memory pins |

## Verification
Two things can happen on the same clock edge: the completion of one access and the acceptance of the next. This matters most when a read is followed at once by a write, because the write's drive-enable then comes up one cycle after output enable rises. The bench provokes this by presenting the next request exactly in the cycle done is high, both read-then-write and write-then-read. It judges the result three ways. The new access's done must arrive three edges later. The drive-enable must never overlap a cycle in which the memory model could be driving. Every word read back must match the bench's own store.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } ctl_state_e;

    // Round a time up to whole clock cycles.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
    parameter int LANES = 2
) (
    input  logic [LANES*8-1:0] raw,
    input  logic [LANES-1:0]   lane_n,
    output logic [LANES*8-1:0] kept
);
    // A lane that was not enabled carries nothing valid: return zero for it.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign kept[g*8 +: 8] = lane_n[g] ? 8'h00 : raw[g*8 +: 8];
    end
endmodule

// File: rtl/sram_turn_guard.sv
module sram_turn_guard #(
    parameter int TURN_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic ok
);
    localparam int            TW     = $clog2(TURN_CYC + 1);
    localparam logic [TW-1:0] LOAD_V = TW'(TURN_CYC - 1);

    logic [TW-1:0] wait_d, wait_q;

    // Cycles still to wait before our own drive may turn on. The hold
    // cycle after a read already provides one cycle of the gap.
    always_comb begin
        wait_d = wait_q;
        if (load) begin
            wait_d = LOAD_V;
        end else if (wait_q != '0) begin
            wait_d = wait_q - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else begin
            wait_q <= wait_d;
        end
    end

    assign ok = (wait_q == '0);
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int LANES   = DATA_W / 8,
    parameter int CLK_PS  = 10000,
    parameter int T_WP_PS = 9000,   // write strobe low, minimum
    parameter int T_CW_PS = 9000,   // select to end of write, minimum
    parameter int T_DS_PS = 7000,   // data valid before write strobe rises
    parameter int T_WC_PS = 12000,  // write cycle, minimum
    parameter int T_AA_PS = 12000,  // address to read data valid
    parameter int T_RC_PS = 12000,  // read cycle, minimum
    parameter int T_HZ_PS = 6000    // memory output release after OE/CS rise
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_lane_n,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_oe,
    input  logic [DATA_W-1:0] mem_rdata
);
    // Strobe phase of a write: the write-strobe width, with select-to-end
    // and data setup measured from the setup edge, and the full cycle.
    localparam int WR_STB = max2(1, max2(ceil_div(T_WP_PS, CLK_PS),
                            max2(ceil_div(T_CW_PS, CLK_PS) - 1,
                            max2(ceil_div(T_DS_PS, CLK_PS) - 1,
                                 ceil_div(T_WC_PS, CLK_PS) - 2))));
    // Strobe phase of a read: access time counted from the setup edge.
    localparam int RD_STB = max2(1, max2(ceil_div(T_AA_PS, CLK_PS) - 1,
                                         ceil_div(T_RC_PS, CLK_PS) - 1));
    localparam int TURN_CYC = max2(1, ceil_div(T_HZ_PS, CLK_PS));
    localparam int CNT_W    = $clog2(max2(WR_STB, RD_STB) + 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_STB - 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_STB - 1);

    typedef struct packed {
        ctl_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lane_n;
        logic [DATA_W-1:0] wdata;
        logic              is_wr;
        logic [CNT_W-1:0]  cnt;
        logic              cs_n;
        logic              we_n;
        logic              oe_n;
        logic              drv;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        state:  ST_IDLE,
        addr:   '0,
        lane_n: '1,
        wdata:  '0,
        is_wr:  1'b0,
        cnt:    '0,
        cs_n:   1'b1,
        we_n:   1'b1,
        oe_n:   1'b1,
        drv:    1'b0,
        done:   1'b0,
        rdata:  '0
    };

    ctl_t              ctl_d, ctl_q;
    logic              turn_ok;
    logic              rd_finish;
    logic [DATA_W-1:0] lane_data;

    sram_lane_mask #(.LANES(LANES)) u_lane_mask (
        .raw    (mem_rdata),
        .lane_n (ctl_q.lane_n),
        .kept   (lane_data)
    );

    sram_turn_guard #(.TURN_CYC(TURN_CYC)) u_turn_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rd_finish),
        .ok    (turn_ok)
    );

    // A read leaves its strobe phase on this edge: memory starts releasing.
    assign rd_finish = (ctl_q.state == ST_STROBE) && (ctl_q.cnt == '0) && !ctl_q.is_wr;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE, ST_HOLD: begin
                ctl_d.state  = ST_IDLE;
                ctl_d.cs_n   = 1'b1;
                ctl_d.we_n   = 1'b1;
                ctl_d.oe_n   = 1'b1;
                ctl_d.lane_n = '1;
                ctl_d.drv    = 1'b0;
                if (req) begin
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.is_wr = req_wr;
                    if (req_mask == '0) begin
                        // Nothing to move: finish without touching the pins.
                        ctl_d.state = ST_HOLD;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.state  = ST_SETUP;
                        ctl_d.cs_n   = 1'b0;
                        ctl_d.lane_n = ~req_mask;
                        ctl_d.oe_n   = req_wr;
                        ctl_d.drv    = req_wr && turn_ok;
                    end
                end
            end
            ST_SETUP: begin
                if (ctl_q.is_wr && !ctl_q.drv) begin
                    // Bus still being released after a read: keep waiting.
                    ctl_d.drv = turn_ok;
                end else begin
                    ctl_d.state = ST_STROBE;
                    ctl_d.we_n  = !ctl_q.is_wr;
                    ctl_d.cnt   = ctl_q.is_wr ? WR_LOAD : RD_LOAD;
                end
            end
            ST_STROBE: begin
                if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
                end else begin
                    ctl_d.state  = ST_HOLD;
                    ctl_d.cs_n   = 1'b1;
                    ctl_d.we_n   = 1'b1;
                    ctl_d.oe_n   = 1'b1;
                    ctl_d.lane_n = '1;
                    ctl_d.drv    = 1'b0;
                    ctl_d.done   = 1'b1;
                    if (!ctl_q.is_wr) begin
                        ctl_d.rdata = lane_data;
                    end
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done         = ctl_q.done;
    assign rd_data      = ctl_q.rdata;
    assign mem_addr     = ctl_q.addr;
    assign mem_cs_n     = ctl_q.cs_n;
    assign mem_we_n     = ctl_q.we_n;
    assign mem_oe_n     = ctl_q.oe_n;
    assign mem_lane_n   = ctl_q.lane_n;
    assign mem_wdata    = ctl_q.wdata;
    assign mem_wdata_oe = ctl_q.drv;

    // R2, R12: a write strobe only under select, with output enable high and drive on.
    p_write_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_wdata_oe));

    // R2: select is already low in the cycle before the write strobe falls.
    p_cs_leads_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_cs_n));

    // R10: no drive while, or just after, the memory may drive the pins.
    p_drive_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wdata_oe |-> (mem_oe_n && $past(mem_oe_n)));

    // R11: address and lanes stay put while select stays low.
    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_lane_n)));

    // R3: select low always comes with at least one lane enabled.
    p_lane_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> (mem_lane_n != '1));

    // R6, R10: in the done cycle the memory is deselected and drive is off.
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_cs_n && !mem_wdata_oe));

endmodule

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        done;
    logic [15:0] rd_data;
    logic [15:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_wdata;
    logic        mem_wdata_oe;
    logic [15:0] mem_rdata;

    always #5 clk = ~clk;

    sram_ctl u_sram_ctl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .done(done), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lane_n(mem_lane_n), .mem_wdata(mem_wdata),
        .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int          at;
        bit          rd;
        logic [15:0] data;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    exp_t        e_now;
    logic [15:0] dev_mem [int];   // the memory device model
    logic [15:0] ref_mem [int];   // the bench's expected contents
    logic [15:0] last_rd = 16'h0;
    logic [15:0] cur_word = 16'h0;
    bit          prev_mem_drive = 0;
    bit          prev_cs_low = 0;
    bit          prev_we_low = 0;
    logic [15:0] prev_addr = '0;
    logic [1:0]  prev_lane = '1;
    int          rd_run = 0;
    int          cs_low_cnt = 0;

    function automatic logic [15:0] dev_rd(input int a);
        return dev_mem.exists(a) ? dev_mem[a] : 16'h0;
    endfunction

    function automatic logic [15:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 16'h0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Memory pins: drive read data only when selected, enabled and not writing.
    assign mem_rdata = (!mem_cs_n && !mem_oe_n && mem_we_n)
                     ? {mem_lane_n[1] ? 8'hA5 : cur_word[15:8],
                        mem_lane_n[0] ? 8'h5A : cur_word[7:0]}
                     : 16'hC3C3;

    always @(posedge clk) cyc <= cyc + 1;

    // Cycle-by-cycle reference comparison and memory model.
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_q.size() != 0 && exp_q[0].at == cyc) begin
                e_now = exp_q.pop_front();
                check(done == 1'b1, {e_now.tag, " done timing"}, done, 1);
                if (e_now.rd)
                    check(rd_data == e_now.data, {e_now.tag, " read data"}, rd_data, e_now.data);
            end else if (done) begin
                check(1'b0, "R6 unexpected done", done, 0);
            end
            if (mem_wdata_oe) begin
                check(mem_oe_n && !prev_mem_drive, "R10 drive overlap", {mem_oe_n, prev_mem_drive}, 2'b10);
                check(!done, "R10 drive in done cycle", done, 0);
            end
            if (!mem_we_n) begin
                check(!mem_cs_n && mem_oe_n && prev_cs_low && !prev_we_low, "R2 write strobe shape",
                      {mem_cs_n, mem_oe_n, prev_cs_low, prev_we_low}, 4'b0110);
                for (int l = 0; l < 2; l++) begin
                    if (!mem_lane_n[l]) begin
                        check(mem_wdata_oe, "R12 drive during write", mem_wdata_oe, 1);
                        cur_word[l*8 +: 8] = mem_wdata[l*8 +: 8];
                    end
                end
                dev_mem[int'(mem_addr)] = cur_word;
            end
            if (!mem_cs_n && prev_cs_low)
                check(mem_addr == prev_addr && mem_lane_n == prev_lane, "R11 address hold",
                      {mem_addr, mem_lane_n}, {prev_addr, prev_lane});
            if (!mem_cs_n && !mem_oe_n) begin
                rd_run++;
            end else if (rd_run != 0) begin
                check(rd_run == 2, "R4 read window", rd_run, 2);
                rd_run = 0;
            end
            if (!mem_cs_n) cs_low_cnt++;
            prev_mem_drive = !mem_cs_n && !mem_oe_n && mem_we_n;
            prev_cs_low    = !mem_cs_n;
            prev_we_low    = !mem_we_n;
            prev_addr      = mem_addr;
            prev_lane      = mem_lane_n;
            cur_word       = dev_rd(int'(mem_addr));
        end
    end

    // Present one request at the current falling edge; return its done cycle.
    task automatic issue(input bit wr, input int a, input logic [15:0] d,
                         input logic [1:0] m, input string tag, output int dcyc);
        exp_t        e;
        logic [15:0] w;
        dcyc  = cyc + ((m == 2'b00) ? 1 : 3);
        e.at  = dcyc;
        e.tag = tag;
        if (m == 2'b00) begin
            e.rd = 1; e.data = last_rd;
        end else if (wr) begin
            w = ref_rd(a);
            if (m[0]) w[7:0]  = d[7:0];
            if (m[1]) w[15:8] = d[15:8];
            ref_mem[a] = w;
            e.rd = 0; e.data = '0;
        end else begin
            w = ref_rd(a);
            e.rd = 1;
            e.data = {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
            last_rd = e.data;
        end
        exp_q.push_back(e);
        req = 1'b1; req_wr = wr; req_addr = a[15:0]; req_wdata = d; req_mask = m;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_to(input int dcyc);
        while (cyc < dcyc) @(negedge clk);
    endtask

    task automatic op(input bit wr, input int a, input logic [15:0] d,
                      input logic [1:0] m, input string tag);
        int dc;
        issue(wr, a, d, m, tag, dc);
        wait_to(dc);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int d1, d2, d3, cs_before;
        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n && mem_lane_n == 2'b11 && !mem_wdata_oe
              && !done && rd_data == 16'h0, "R1 reset levels",
              {mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n, mem_wdata_oe, done}, 7'b1111100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Full-word write and read-back (R2, R4, R6).
        op(1, 16'h0010, 16'h1234, 2'b11, "R2");
        op(0, 16'h0010, 16'h0000, 2'b11, "R4");
        // Low lane only, then high lane only (R3).
        op(1, 16'h0010, 16'hABCD, 2'b01, "R3");
        op(0, 16'h0010, 16'h0000, 2'b11, "R3");
        op(1, 16'h0010, 16'h77EE, 2'b10, "R3");
        op(0, 16'h0010, 16'h0000, 2'b11, "R3");
        // Single-lane reads return zero in the other lane (R5).
        op(0, 16'h0010, 16'h0000, 2'b10, "R5");
        op(0, 16'h0010, 16'h0000, 2'b01, "R5");
        // Empty mask: done only, no strobes, no store, data kept (R7).
        cs_before = cs_low_cnt;
        op(1, 16'h0010, 16'hFFFF, 2'b00, "R7");
        check(cs_low_cnt == cs_before, "R7 no strobe", cs_low_cnt, cs_before);
        op(0, 16'h0010, 16'h0000, 2'b00, "R7");
        op(0, 16'h0010, 16'h0000, 2'b11, "R7");
        // Back-to-back: write, read, write, read, each taken in the done cycle (R8, R10).
        issue(1, 16'h0020, 16'h5555, 2'b11, "R8", d1);
        wait_to(d1);
        issue(0, 16'h0020, 16'h0000, 2'b11, "R8", d2);
        wait_to(d2);
        issue(1, 16'h0021, 16'h6A6A, 2'b11, "R10", d3);
        wait_to(d3);
        issue(0, 16'h0021, 16'h0000, 2'b11, "R8", d1);
        wait_to(d1);
        // Null request in a done cycle, then a read in the next done cycle.
        issue(1, 16'h0021, 16'h0000, 2'b00, "R8", d2);
        wait_to(d2);
        issue(0, 16'h0020, 16'h0000, 2'b01, "R8", d3);
        wait_to(d3);
        @(negedge clk);
        // Request while busy is dropped (R9).
        issue(1, 16'h0030, 16'h9999, 2'b11, "R9", d1);
        req = 1'b1; req_wr = 1'b1; req_addr = 16'h0030; req_wdata = 16'h1111; req_mask = 2'b11;
        @(negedge clk);
        req = 1'b1; req_addr = 16'h0031;
        @(negedge clk);
        req = 1'b0;
        wait_to(d1);
        @(negedge clk);
        op(0, 16'h0030, 16'h0000, 2'b11, "R9");
        op(0, 16'h0031, 16'h0000, 2'b11, "R9");
        // Address range ends.
        op(1, 16'hFFFF, 16'hC0DE, 2'b11, "R2");
        op(1, 16'h0000, 16'h0BAD, 2'b11, "R2");
        op(0, 16'hFFFF, 16'h0000, 2'b11, "R4");
        op(0, 16'h0000, 16'h0000, 2'b11, "R4");
        // Patterned sweep with mixed masks.
        for (int i = 0; i < 8; i++)
            op(1, 16'h0100 + i, 16'(i * 16'h1111) ^ 16'h0F0F, 2'(i % 3 + 1), "R3");
        for (int i = 0; i < 8; i++)
            op(0, 16'h0100 + i, 16'h0000, 2'b11, "R4");
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R6 all completed", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule